// File: doc/BRIEF.md
# PWM Tick Generator

This block produces the count-enable strobes for a five-channel timer from a single reference clock (nominally 24 MHz). Two 8-bit prescalers slow the reference by (value + 1). The first serves channels 0 and 1 and the second serves channels 2, 3 and 4. Each channel then divides its prescaled pulse train by a power of two that it selects itself. A channel's strobe rate is therefore the reference rate divided by (prescale + 1) · 2^select.

Software programs the block through a one-cycle write port that has two registers. The prescale register holds both prescaler values. The divide register holds five 4-bit select fields. A write to either register restarts every prescaler and every channel divider together, so all five channels take up new settings in the same cycle. Each strobe is a single-cycle, registered enable in the reference clock domain, ready to gate a down-counter.

Top module: `pwm_tick_gen`

## Requirements
- R1: While rst_n is low every tick bit is 0. Reset loads a prescale value of 1 into both prescalers and a select of 0 into every channel, so after reset every channel strobes once every 2 cycles.
- R2: A write with cfg_addr = 0 loads prescaler A from cfg_wdata[7:0] and prescaler B from cfg_wdata[15:8]. Bits 19:16 of that write have no effect.
- R3: A write with cfg_addr = 1 loads the select of channel n from cfg_wdata[4n+3:4n]. The divide factor of the channel is 2 raised to the select.
- R4: A select value above 4 acts as a select of 4, which is divide-by-16.
- R5: Channels 0 and 1 count pulses of prescaler A. Channels 2, 3 and 4 count pulses of prescaler B.
- R6: Each tick bit is high for single cycles with a period of exactly (prescale + 1) · factor cycles. This holds up to the largest setting, which is 256 · 16 = 4096 cycles.
- R7: A write to either register restarts all counters. No tick is high in the cycle after the write edge. A channel's first tick comes exactly period cycles after the write edge, so in the cycle after the edge that is period cycles later.
- R8: Channels that share a prescaler and have equal effective selects always tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | One-cycle register write strobe |
| cfg_addr | input | 1 | 0 selects the prescale register, 1 selects the divide register |
| cfg_wdata | input | 20 | Write data |
| tick | output | 5 | Per-channel count-enable strobes, bit n for channel n |

## Verification
Two events can fall in the same cycle: a register write, and the terminal count of a prescaler or divider that would have produced a tick. The write must win. It suppresses that tick and restarts the count from the write edge. The random phase issues writes at arbitrary distances from one another, often inside a single period. It compares every strobe each cycle against a bench model that knows only the number of edges since the last write and the programmed period. A tick that is late, early or not suppressed therefore shows up as a mismatch.

// File: rtl/ptg_pkg.sv
package ptg_pkg;
  localparam int unsigned NUM_CH  = 5;
  localparam int unsigned PRE_W   = 8;
  localparam int unsigned SEL_W   = 4;
  localparam int unsigned MAX_SEL = 4;
  localparam int unsigned SPLIT   = 2;  // first channel served by prescaler B
  localparam int unsigned NUM_PRE = 2;

  // prescaler index that feeds a channel
  function automatic int unsigned pre_of(input int unsigned ch, input int unsigned split);
    return (ch < split) ? 0 : 1;
  endfunction

  // effective select after clamping
  function automatic logic [SEL_W-1:0] clamp_sel(input logic [SEL_W-1:0] s);
    return (s > SEL_W'(MAX_SEL)) ? SEL_W'(MAX_SEL) : s;
  endfunction

  // low 'sel' bits set: divide counter value at which a tick is due
  function automatic logic [MAX_SEL-1:0] sel_mask(input logic [SEL_W-1:0] sel);
    logic [MAX_SEL-1:0] m;
    m = '0;
    for (int i = 0; i < int'(MAX_SEL); i++) begin
      if (i < int'(sel)) m[i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/ptg_prescaler.sv
module ptg_prescaler #(
  parameter int unsigned PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [PRE_W-1:0] limit,
  output logic             pulse
);
  logic [PRE_W-1:0] cnt_q;

  assign pulse = (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (pulse)   cnt_q <= '0;
    else              cnt_q <= cnt_q + PRE_W'(1);
  end
endmodule

// File: rtl/ptg_divider.sv
module ptg_divider
  import ptg_pkg::*;
#(
  parameter int unsigned SEL_W   = ptg_pkg::SEL_W,
  parameter int unsigned MAX_SEL = ptg_pkg::MAX_SEL
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             pre_pulse,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [MAX_SEL-1:0] dcnt_q;
  logic [MAX_SEL-1:0] mask;
  logic               hit;

  assign mask = sel_mask(sel);
  assign hit  = pre_pulse && ((dcnt_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt_q <= '0;
      tick   <= 1'b0;
    end else if (restart) begin
      dcnt_q <= '0;
      tick   <= 1'b0;
    end else begin
      if (pre_pulse) dcnt_q <= dcnt_q + MAX_SEL'(1);
      tick <= hit;
    end
  end
endmodule

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen
  import ptg_pkg::*;
#(
  parameter int unsigned NUM_CH  = ptg_pkg::NUM_CH,
  parameter int unsigned PRE_W   = ptg_pkg::PRE_W,
  parameter int unsigned SEL_W   = ptg_pkg::SEL_W,
  parameter int unsigned MAX_SEL = ptg_pkg::MAX_SEL,
  parameter int unsigned SPLIT   = ptg_pkg::SPLIT,
  localparam int unsigned CFG0_W = NUM_PRE * PRE_W,
  localparam int unsigned CFG1_W = NUM_CH * SEL_W,
  localparam int unsigned WD_W   = (CFG0_W > CFG1_W) ? CFG0_W : CFG1_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_addr,
  input  logic [WD_W-1:0]   cfg_wdata,
  output logic [NUM_CH-1:0] tick
);
  localparam logic [CFG0_W-1:0] CFG0_RST = {NUM_PRE{PRE_W'(1)}};

  logic [CFG0_W-1:0]       cfg0_q;
  logic [CFG1_W-1:0]       cfg1_q;
  logic                    restart;
  logic [NUM_PRE-1:0]      pre_pulse;
  logic [CFG1_W-1:0]       sel_eff;

  assign restart = cfg_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg0_q <= CFG0_RST;
      cfg1_q <= '0;
    end else if (cfg_we) begin
      if (!cfg_addr) cfg0_q <= cfg_wdata[CFG0_W-1:0];
      else           cfg1_q <= cfg_wdata[CFG1_W-1:0];
    end
  end

  for (genvar g = 0; g < int'(NUM_PRE); g++) begin : g_pre
    ptg_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .limit   (cfg0_q[g*PRE_W +: PRE_W]),
      .pulse   (pre_pulse[g])
    );
  end

  for (genvar n = 0; n < int'(NUM_CH); n++) begin : g_ch
    localparam int unsigned PIDX = pre_of(n, SPLIT);
    assign sel_eff[n*SEL_W +: SEL_W] = clamp_sel(cfg1_q[n*SEL_W +: SEL_W]);
    ptg_divider #(.SEL_W(SEL_W), .MAX_SEL(MAX_SEL)) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (restart),
      .pre_pulse (pre_pulse[PIDX]),
      .sel       (sel_eff[n*SEL_W +: SEL_W]),
      .tick      (tick[n])
    );
  end
endmodule

// File: rtl/ptg_checker.sv
module ptg_checker #(
  parameter int unsigned NUM_CH = 5,
  parameter int unsigned PRE_W  = 8,
  parameter int unsigned SEL_W  = 4,
  parameter int unsigned SPLIT  = 2,
  parameter int unsigned NPRE   = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cfg_we,
  input logic [NUM_CH-1:0]       tick,
  input logic [NPRE-1:0]         pre_pulse,
  input logic [NPRE*PRE_W-1:0]   cfg0_q,
  input logic [NUM_CH*SEL_W-1:0] sel_eff
);
  p_reset_idle_r1: assert property (@(posedge clk) !rst_n |-> tick == '0);

  p_write_mutes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> tick == '0);

  for (genvar g = 0; g < int'(NPRE); g++) begin : g_pre_chk
    p_pre_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pre_pulse[g] && (cfg0_q[g*PRE_W +: PRE_W] != '0) && !cfg_we |=> !pre_pulse[g]);
  end

  for (genvar n = 0; n < int'(NUM_CH); n++) begin : g_ch_chk
    localparam int unsigned PIDX = (n < SPLIT) ? 0 : 1;
    p_tick_from_pre_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tick[n] |-> $past(pre_pulse[PIDX]));
  end

  p_shared_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tick[0] && $stable(sel_eff) && (sel_eff[SEL_W-1:0] == sel_eff[2*SEL_W-1:SEL_W])
    |-> tick[1]);
endmodule

bind pwm_tick_gen ptg_checker #(
  .NUM_CH(NUM_CH), .PRE_W(PRE_W), .SEL_W(SEL_W), .SPLIT(SPLIT), .NPRE(ptg_pkg::NUM_PRE)
) u_ptg_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .tick      (tick),
  .pre_pulse (pre_pulse),
  .cfg0_q    (cfg0_q),
  .sel_eff   (sel_eff)
);

// File: tb/test_pwm_tick_gen.sv
module test_pwm_tick_gen;
  localparam int NCH = 5;
  localparam real HALF = 2.5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_addr = 1'b0;
  logic [19:0] cfg_wdata = '0;
  logic [4:0]  tick;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench model
  int n_since = 0;
  int pre_v [2];
  int sel_v [NCH];

  always #(HALF) clk = ~clk;

  pwm_tick_gen i_pwm_tick_gen (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .tick(tick)
  );

  function automatic int period_of(int ch);
    int s;
    s = (sel_v[ch] > 4) ? 4 : sel_v[ch];
    return (pre_v[(ch < 2) ? 0 : 1] + 1) * (1 << s);
  endfunction

  function automatic logic [4:0] expect_tick();
    logic [4:0] e;
    for (int c = 0; c < NCH; c++)
      e[c] = (n_since > 0) && ((n_since % period_of(c)) == 0);
    return e;
  endfunction

  task automatic compare(string tag, logic [4:0] exp_v);
    checks++;
    if (tick !== exp_v) begin
      fails++;
      $display("FAIL %s: tick actual=%b expected=%b (cycles since restart %0d)",
               tag, tick, exp_v, n_since);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic cyc(bit we, bit addr, logic [19:0] data, string tag);
    cfg_we = we; cfg_addr = addr; cfg_wdata = data;
    @(posedge clk);
    if (we) begin
      n_since = 0;
      if (!addr) begin
        pre_v[0] = int'(data[7:0]);
        pre_v[1] = int'(data[15:8]);
      end else begin
        for (int c = 0; c < NCH; c++) sel_v[c] = int'((data >> (4*c)) & 20'hF);
      end
    end else begin
      n_since++;
    end
    @(negedge clk);
    cfg_we = 1'b0;
    compare(tag, expect_tick());
  endtask

  task automatic idle(int k, string tag);
    for (int i = 0; i < k; i++) cyc(1'b0, 1'b0, '0, tag);
  endtask

  initial begin
    void'($urandom(5150));
    pre_v[0] = 1; pre_v[1] = 1;
    for (int c = 0; c < NCH; c++) sel_v[c] = 0;

    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R1 reset", 5'b0);
    rst_n = 1'b1;
    n_since = 0;
    idle(20, "R1 default period 2");

    // R2/R5: prescaler A=0, B=3, junk in bits 19:16
    cyc(1'b1, 1'b0, 20'hF_0300, "R2 write");
    idle(40, "R2/R5 split prescalers");

    // R3: selects 1,2,3,0,4 for channels 0..4
    cyc(1'b1, 1'b1, 20'h4_0321, "R3 write");
    idle(80, "R3 per-channel factor");

    // R4: selects 5,9,15,7,4 all act as 16
    cyc(1'b1, 1'b1, 20'h4_7F95, "R4 write");
    idle(140, "R4 clamp");

    // R8: equal selects within each group
    cyc(1'b1, 1'b1, 20'h2_2211, "R8 write");
    idle(50, "R8 shared phase");

    // R7: writes close together, landing on pending ticks
    cyc(1'b1, 1'b0, 20'h0_0000, "R7 write");
    cyc(1'b1, 1'b1, 20'h0_0000, "R7 back-to-back");
    idle(3, "R7 after write");
    cyc(1'b1, 1'b0, 20'h0_0101, "R7 mid-period");
    idle(6, "R7 restart");

    // R7/R6: random mix of writes and idle cycles
    for (int i = 0; i < 600; i++) begin
      if (($urandom % 8) == 0) begin
        if ($urandom % 2)
          cyc(1'b1, 1'b0, {4'($urandom), 8'($urandom % 4), 8'($urandom % 4)}, "R7 random write");
        else
          cyc(1'b1, 1'b1, 20'($urandom), "R7 random write");
      end else begin
        cyc(1'b0, 1'b0, 20'($urandom), "R6 random idle");
      end
    end

    // R6: largest period 256*16
    cyc(1'b1, 1'b0, 20'h0_FFFF, "R6 max write");
    cyc(1'b1, 1'b1, 20'h4_4444, "R6 max write");
    idle(8300, "R6 max period");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(HALF * 2 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule